// File: doc/BRIEF.md
# Three-Wire Serial Frame Transmitter

This block is the host side of a three-wire write link to a bank of converter channels. A requester presents a 4-bit channel code and an 8-bit value together with a one-cycle start strobe. The block captures both, arranges them into a 12-bit frame, and sends the frame one bit per serial clock period on a data line. After the last bit it raises a load strobe, which tells the receiving device to transfer the frame into the selected channel.

Every interface time (clock low and high widths, data setup and hold around the rising serial clock edge, load setup after the last edge, load width, and the hold time before the next frame's first edge) is a nanosecond parameter. Each is converted at elaboration into a count of system clock cycles, rounding up, from a system clock frequency parameter. A busy flag and a one-cycle done pulse form the handshake with the requester.

Top module: `ser_frame_tx`

## Requirements
- R1: Frame bit Dk is held at position k. D7..D0 carry the value with D0 as its least significant bit. D11..D8 carry the channel code with D8 as its most significant bit, so D8 is channel bit 3 and D11 is channel bit 0.
- R2: Bits go out on `ser_data_o` from D11 first to D0 last, and each bit is valid at a rising edge of `ser_clk_o`.
- R3: `ser_clk_o` stays low for at least ceil(T_CLK_LOW_NS·CLK_MHZ/1000) cycles before each rise. `ser_data_o` is stable for at least the rounded-up setup count before that rise.
- R4: `ser_clk_o` stays high for at least the rounded-up high-time count. `ser_data_o` changes no sooner than the rounded-up hold count after a rise.
- R5: Each frame has exactly 12 rising edges of `ser_clk_o` before the load strobe rises.
- R6: `ser_load_o` rises at least the rounded-up load-setup count after the final rising edge, and `ser_clk_o` is low the whole time `ser_load_o` is high.
- R7: `ser_load_o` stays high for at least the rounded-up load-width count.
- R8: The first rising edge of a frame comes at least the rounded-up load-hold count after the previous load strobe fell.
- R9: A start strobe while `busy_o` is high is ignored: no extra frame is sent and the frame in progress is unchanged.
- R10: `busy_o` rises in the cycle after an accepted start and stays high until `ser_load_o` falls. `done_o` is high for exactly one cycle, starting at the same edge where `ser_load_o` falls, with `busy_o` low.
- R11: Out of reset and whenever idle, `ser_clk_o`, `ser_load_o`, `ser_data_o`, `busy_o` and `done_o` are low.
- R12: A start strobe sampled in the cycle where `done_o` is high is accepted.
- R13: Channel and value are captured when the start strobe is accepted. Later changes on those inputs do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, one cycle |
| chan_i | input | 4 | Channel code for the request |
| value_i | input | 8 | Value for the request |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ser_clk_o | output | 1 | Serial clock |
| ser_data_o | output | 1 | Serial data |
| ser_load_o | output | 1 | Load strobe |

## Verification
Two events can land in the same system clock cycle: the completion pulse of one frame and the acceptance of the next request. The bench provokes this by driving a start strobe in the very sample where `done_o` is seen high. It expects `busy_o` to be high again one cycle later, both frames to reach the scoreboard with the right bits, and the first serial edge of the new frame to still respect the load-hold spacing.

// File: rtl/ser_frame_pkg.sv
`timescale 1ns/1ps
package ser_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOW  = 3'd1,
    ST_HIGH = 3'd2,
    ST_GAP  = 3'd3,
    ST_LOAD = 3'd4
  } tx_state_e;

  // minimum time in ns -> whole system clock cycles, rounded up
  function automatic int ns_to_cycles(input int t_ns, input int clk_mhz);
    return (t_ns * clk_mhz + 999) / 1000;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ser_frame_pack.sv
`timescale 1ns/1ps
// Arranges channel and value into frame positions D(FRAME_W-1)..D0.
module ser_frame_pack #(
  parameter int CHAN_W = 4,
  parameter int VAL_W  = 8,
  localparam int FRAME_W = CHAN_W + VAL_W
) (
  input  logic [CHAN_W-1:0]  chan,
  input  logic [VAL_W-1:0]   value,
  output logic [FRAME_W-1:0] frame
);

  assign frame[VAL_W-1:0] = value;

  // channel field is stored reversed: its MSB sits just above the value
  for (genvar j = 0; j < CHAN_W; j++) begin : g_chan_bit
    assign frame[VAL_W+j] = chan[CHAN_W-1-j];
  end

endmodule

// File: rtl/ser_phase_timer.sv
`timescale 1ns/1ps
// Shared down-counter that times every phase of the frame.
module ser_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = reload || (cnt_q != '0);
  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (reload)            cnt_d = reload_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ser_shifter.sv
`timescale 1ns/1ps
// Frame shift register, MSB first, with remaining-bit count.
module ser_shifter #(
  parameter int FRAME_W = 12,
  localparam int LEFT_W = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic               clear,
  input  logic [FRAME_W-1:0] frame,
  output logic               bit_out,
  output logic               last_bit
);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               sh_en;

  assign sh_en    = load || shift || clear;
  assign bit_out  = sh_q[FRAME_W-1];
  assign last_bit = (left_q == '0);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load) begin
      sh_d   = frame;
      left_d = LEFT_W'(FRAME_W - 1);
    end else if (clear) begin
      sh_d   = '0;
      left_d = '0;
    end else if (shift) begin
      sh_d   = {sh_q[FRAME_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/ser_tx_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer: phases, serial clock, load strobe, handshake.
module ser_tx_ctrl import ser_frame_pkg::*; #(
  parameter int CNT_W     = 6,
  parameter int FIRST_LOW = 40,
  parameter int LOW_PH    = 40,
  parameter int HIGH_PH   = 40,
  parameter int LD_GAP    = 1,
  parameter int LD_HIGH   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tmr_expired,
  input  logic             last_bit,
  output logic             tmr_reload,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             sh_clear,
  output logic             sclk,
  output logic             load,
  output logic             busy,
  output logic             done
);

  tx_state_e state_q, state_d;
  logic      sclk_q, sclk_d;
  logic      load_q, load_d;
  logic      busy_q, busy_d;
  logic      done_q, done_d;

  always_comb begin
    state_d    = state_q;
    sclk_d     = sclk_q;
    load_d     = load_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    tmr_reload = 1'b0;
    tmr_val    = '0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    sh_clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d    = ST_LOW;
          tmr_reload = 1'b1;
          tmr_val    = CNT_W'(FIRST_LOW - 1);
          sh_load    = 1'b1;
          busy_d     = 1'b1;
          sclk_d     = 1'b0;
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          state_d    = ST_HIGH;
          tmr_reload = 1'b1;
          tmr_val    = CNT_W'(HIGH_PH - 1);
          sclk_d     = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          sclk_d     = 1'b0;
          tmr_reload = 1'b1;
          if (last_bit) begin
            state_d  = ST_GAP;
            tmr_val  = CNT_W'(LD_GAP - 1);
            sh_clear = 1'b1;
          end else begin
            state_d  = ST_LOW;
            tmr_val  = CNT_W'(LOW_PH - 1);
            sh_shift = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          state_d    = ST_LOAD;
          tmr_reload = 1'b1;
          tmr_val    = CNT_W'(LD_HIGH - 1);
          load_d     = 1'b1;
        end
      end
      ST_LOAD: begin
        if (tmr_expired) begin
          state_d = ST_IDLE;
          load_d  = 1'b0;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        sclk_d  = 1'b0;
        load_d  = 1'b0;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      load_q  <= load_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign load = load_q;
  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/ser_frame_tx.sv
`timescale 1ns/1ps
// Three-wire serial frame transmitter, top level.
module ser_frame_tx import ser_frame_pkg::*; #(
  parameter int CLK_MHZ         = 200,
  parameter int CHAN_W          = 4,
  parameter int VAL_W           = 8,
  parameter int T_CLK_LOW_NS    = 200,
  parameter int T_CLK_HIGH_NS   = 200,
  parameter int T_SETUP_NS      = 30,
  parameter int T_HOLD_NS       = 60,
  parameter int T_LOAD_SETUP_NS = 200,
  parameter int T_LOAD_HIGH_NS  = 100,
  parameter int T_LOAD_HOLD_NS  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              ser_load_o
);

  localparam int FRAME_W   = CHAN_W + VAL_W;
  localparam int CYC_LOW   = ns_to_cycles(T_CLK_LOW_NS, CLK_MHZ);
  localparam int CYC_HIGH  = ns_to_cycles(T_CLK_HIGH_NS, CLK_MHZ);
  localparam int CYC_SU    = ns_to_cycles(T_SETUP_NS, CLK_MHZ);
  localparam int CYC_HO    = ns_to_cycles(T_HOLD_NS, CLK_MHZ);
  localparam int CYC_LDSU  = ns_to_cycles(T_LOAD_SETUP_NS, CLK_MHZ);
  localparam int CYC_LDHI  = ns_to_cycles(T_LOAD_HIGH_NS, CLK_MHZ);
  localparam int CYC_LDHO  = ns_to_cycles(T_LOAD_HOLD_NS, CLK_MHZ);
  // data moves only at the falling edge, so setup folds into low, hold into high
  localparam int LOW_PH    = max_of(max_of(CYC_LOW, CYC_SU), 1);
  localparam int HIGH_PH   = max_of(max_of(CYC_HIGH, CYC_HO), 1);
  localparam int FIRST_LOW = max_of(LOW_PH, CYC_LDHO);
  localparam int LD_GAP    = (CYC_LDSU > HIGH_PH) ? (CYC_LDSU - HIGH_PH) : 1;
  localparam int LD_HIGH   = max_of(CYC_LDHI, 1);
  localparam int MAX_CYC   = max_of(max_of(FIRST_LOW, HIGH_PH), max_of(LD_GAP, LD_HIGH));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [FRAME_W-1:0] frame;
  logic               tmr_reload, tmr_expired;
  logic [CNT_W-1:0]   tmr_val;
  logic               sh_load, sh_shift, sh_clear, last_bit;

  ser_frame_pack #(.CHAN_W(CHAN_W), .VAL_W(VAL_W)) u_pack (
    .chan  (chan_i),
    .value (value_i),
    .frame (frame)
  );

  ser_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reload     (tmr_reload),
    .reload_val (tmr_val),
    .expired    (tmr_expired)
  );

  ser_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (sh_load),
    .shift    (sh_shift),
    .clear    (sh_clear),
    .frame    (frame),
    .bit_out  (ser_data_o),
    .last_bit (last_bit)
  );

  ser_tx_ctrl #(
    .CNT_W     (CNT_W),
    .FIRST_LOW (FIRST_LOW),
    .LOW_PH    (LOW_PH),
    .HIGH_PH   (HIGH_PH),
    .LD_GAP    (LD_GAP),
    .LD_HIGH   (LD_HIGH)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start_i),
    .tmr_expired (tmr_expired),
    .last_bit    (last_bit),
    .tmr_reload  (tmr_reload),
    .tmr_val     (tmr_val),
    .sh_load     (sh_load),
    .sh_shift    (sh_shift),
    .sh_clear    (sh_clear),
    .sclk        (ser_clk_o),
    .load        (ser_load_o),
    .busy        (busy_o),
    .done        (done_o)
  );

endmodule

// File: rtl/ser_frame_tx_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the transmitter top.
module ser_frame_tx_chk #(
  parameter int LOW_PH   = 40,
  parameter int HIGH_PH  = 40,
  parameter int LD_SETUP = 40,
  parameter int LD_HIGH  = 20,
  parameter int LD_HOLD  = 20
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic load
);

  logic [15:0] low_cnt, high_cnt, ld_cnt, since_rise, since_ld_fall;
  logic        sclk_prev, load_prev;
  logic        rose_now, fell_ld_now;

  assign rose_now    = sclk && !sclk_prev;
  assign fell_ld_now = !load && load_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev     <= 1'b0;
      load_prev     <= 1'b0;
      low_cnt       <= '0;
      high_cnt      <= '0;
      ld_cnt        <= '0;
      since_rise    <= '1;
      since_ld_fall <= '1;
    end else begin
      sclk_prev     <= sclk;
      load_prev     <= load;
      low_cnt       <= sclk ? '0 : ((low_cnt == '1) ? low_cnt : low_cnt + 16'd1);
      high_cnt      <= !sclk ? '0 : ((high_cnt == '1) ? high_cnt : high_cnt + 16'd1);
      ld_cnt        <= !load ? '0 : ((ld_cnt == '1) ? ld_cnt : ld_cnt + 16'd1);
      since_rise    <= rose_now ? 16'd1 : ((since_rise == '1) ? since_rise : since_rise + 16'd1);
      since_ld_fall <= fell_ld_now ? 16'd1 : ((since_ld_fall == '1) ? since_ld_fall : since_ld_fall + 16'd1);
    end
  end

  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (low_cnt >= 16'(LOW_PH)));

  assert_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (high_cnt >= 16'(HIGH_PH)));

  assert_data_still_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdata));

  assert_load_setup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load) |-> (since_rise >= 16'(LD_SETUP)));

  assert_load_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !sclk);

  assert_load_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load) |-> (ld_cnt >= 16'(LD_HIGH)));

  assert_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (since_ld_fall >= 16'(LD_HOLD)));

  assert_load_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> busy);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !load && !sdata));

endmodule

bind ser_frame_tx ser_frame_tx_chk #(
  .LOW_PH   (LOW_PH),
  .HIGH_PH  (HIGH_PH),
  .LD_SETUP (CYC_LDSU),
  .LD_HIGH  (LD_HIGH),
  .LD_HOLD  (CYC_LDHO)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .busy  (busy_o),
  .done  (done_o),
  .sclk  (ser_clk_o),
  .sdata (ser_data_o),
  .load  (ser_load_o)
);

// File: tb/tb_ser_frame_tx.sv
`timescale 1ns/1ps
module tb_ser_frame_tx;

  // 200 MHz -> 5 ns per cycle; minimum counts rounded up from the requirements
  localparam int PER_NS   = 5;
  localparam int LOW_CYC  = (200 + PER_NS - 1) / PER_NS;
  localparam int HIGH_CYC = (200 + PER_NS - 1) / PER_NS;
  localparam int SU_CYC   = (30  + PER_NS - 1) / PER_NS;
  localparam int HO_CYC   = (60  + PER_NS - 1) / PER_NS;
  localparam int LDSU_CYC = (200 + PER_NS - 1) / PER_NS;
  localparam int LDHI_CYC = (100 + PER_NS - 1) / PER_NS;
  localparam int LDHO_CYC = (100 + PER_NS - 1) / PER_NS;

  logic       clk, rst_n, start_i;
  logic [3:0] chan_i;
  logic [7:0] value_i;
  logic       busy_o, done_o, ser_clk_o, ser_data_o, ser_load_o;

  ser_frame_tx dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .chan_i     (chan_i),
    .value_i    (value_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ser_clk_o  (ser_clk_o),
    .ser_data_o (ser_data_o),
    .ser_load_o (ser_load_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int frames_sent = 0;
  int frames_seen = 0;
  logic [11:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial order: channel bit0..bit3, then value bit7..bit0
  function automatic logic [11:0] wire_bits(input logic [3:0] c, input logic [7:0] v);
    return {c[0], c[1], c[2], c[3], v};
  endfunction

  // ---------------- monitor / scoreboard ----------------
  logic        p_sclk, p_sdata, p_load, p_done;
  int          low_run, high_run, ld_run, data_age, since_rise, since_ld_fall, nbits;
  logic [11:0] col;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 0; p_sdata = 0; p_load = 0; p_done = 0;
      low_run = 0; high_run = 0; ld_run = 0; data_age = 0;
      since_rise = 1000; since_ld_fall = 1000; nbits = 0; col = '0;
    end else begin
      if (ser_data_o !== p_sdata) begin
        chk(since_rise >= HO_CYC, "R4 data hold after rise", since_rise, HO_CYC);
        data_age = 0;
      end else begin
        data_age++;
      end
      if (ser_clk_o && !p_sclk) begin
        chk(low_run >= LOW_CYC, "R3 clock low width", low_run, LOW_CYC);
        chk(data_age >= SU_CYC, "R3 data setup", data_age, SU_CYC);
        chk(since_ld_fall >= LDHO_CYC, "R8 load hold before first rise", since_ld_fall, LDHO_CYC);
        col = {col[10:0], ser_data_o};
        nbits++;
        since_rise = 0;
      end else begin
        since_rise++;
      end
      if (!ser_clk_o && p_sclk)
        chk(high_run >= HIGH_CYC, "R4 clock high width", high_run, HIGH_CYC);
      if (ser_load_o && !p_load) begin
        chk(!ser_clk_o, "R6 clock low at load", ser_clk_o, 0);
        chk(since_rise >= LDSU_CYC, "R6 load setup", since_rise, LDSU_CYC);
        chk(nbits == 12, "R5 rising edges per frame", nbits, 12);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected frame", col, 0);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          chk(col == e, "R1 R2 frame bits", col, e);
        end
        nbits = 0;
      end
      if (!ser_load_o && p_load) begin
        chk(ld_run >= LDHI_CYC, "R7 load width", ld_run, LDHI_CYC);
        chk(done_o && !busy_o, "R10 done with load fall", {busy_o, done_o}, 1);
        since_ld_fall = 0;
        frames_seen++;
      end else begin
        since_ld_fall++;
      end
      if (p_done) chk(!done_o, "R10 done single cycle", done_o, 0);
      low_run  = ser_clk_o  ? 0 : low_run + 1;
      high_run = ser_clk_o  ? high_run + 1 : 0;
      ld_run   = ser_load_o ? ld_run + 1 : 0;
      p_sclk = ser_clk_o; p_sdata = ser_data_o; p_load = ser_load_o; p_done = done_o;
    end
  end

  // ---------------- driver ----------------
  task automatic send(input logic [3:0] c, input logic [7:0] v);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    chan_i = c; value_i = v; start_i = 1'b1;
    exp_q.push_back(wire_bits(c, v));
    frames_sent++;
    @(negedge clk);
    start_i = 1'b0;
    chan_i = ~c; value_i = ~v;   // R13: later input changes must not matter
    chk(busy_o, "R10 busy after accept", busy_o, 1);
  endtask

  task automatic send_on_done(input logic [3:0] c, input logic [7:0] v);
    @(negedge clk);
    while (!done_o) @(negedge clk);
    chan_i = c; value_i = v; start_i = 1'b1;
    exp_q.push_back(wire_bits(c, v));
    frames_sent++;
    @(negedge clk);
    start_i = 1'b0;
    chan_i = 4'h0; value_i = 8'h00;
    chk(busy_o, "R12 start in done cycle accepted", busy_o, 1);
  endtask

  task automatic poke_while_busy(input logic [3:0] c, input logic [7:0] v);
    @(negedge clk);
    while (!busy_o || ser_load_o) @(negedge clk);
    repeat (100) @(negedge clk);
    chan_i = c; value_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R9 busy unaffected by start", busy_o, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: run did not finish actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; start_i = 1'b0; chan_i = '0; value_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!ser_clk_o,  "R11 reset clock low", ser_clk_o, 0);
    chk(!ser_load_o, "R11 reset load low", ser_load_o, 0);
    chk(!ser_data_o, "R11 reset data low", ser_data_o, 0);
    chk(!busy_o,     "R11 reset busy low", busy_o, 0);
    chk(!done_o,     "R11 reset done low", done_o, 0);

    // R1 R2 R13: distinct patterns
    send(4'h0, 8'h00);
    send(4'h1, 8'h01);
    send(4'h8, 8'h80);
    send(4'hF, 8'hFF);
    send(4'h5, 8'hA5);

    // R9: start during a frame is ignored
    send(4'hA, 8'h3C);
    poke_while_busy(4'h3, 8'h77);

    // R12: new request in the done cycle
    send_on_done(4'h6, 8'h5A);
    send_on_done(4'h9, 8'hC3);

    for (int i = 0; i < 3; i++) begin
      logic [11:0] r;
      r = 12'($urandom);
      send(r[11:8], r[7:0]);
    end

    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (10) @(negedge clk);
    // R11: idle state after traffic
    chk(!ser_clk_o,  "R11 idle clock low", ser_clk_o, 0);
    chk(!ser_load_o, "R11 idle load low", ser_load_o, 0);
    chk(!ser_data_o, "R11 idle data low", ser_data_o, 0);
    chk(frames_seen == frames_sent, "R9 frame count", frames_seen, frames_sent);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule